// File: doc/BRIEF.md
# Bus-Controlled GPIO Bank With Edge and Level Interrupts

This block is a bank of general-purpose I/O lines managed through a small 32-bit register bus. Software can read the level of each line, set the value each line drives, choose per line whether the output driver is on, and enable interrupts per line. The pad cell sits outside the block and receives an output value and an output-enable per line.

The interrupt trigger behaviour is chosen when the block is built, through a parameter. Four modes exist: rising edge, falling edge, either edge, and level high. In the three edge modes, detected transitions set sticky bits in a capture register. Software clears those bits by writing ones to them. In level mode the capture register is not used: a line is pending whenever its synchronized level is high and its enable bit is set.

A single registered interrupt line is raised while any enabled line is pending. Incoming pin levels pass through a two-stage synchronizer before they are used for reads, edge detection or level interrupts.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output data, output-enable, interrupt-enable and capture registers are all zero, the interrupt output is low, and the read data bus is zero.
- R2: A read at byte offset 0x0 returns the pin levels, delayed by a two-flop synchronizer, with bit i holding line i and the bits at LINES and above reading zero. Read data appears on the bus one clock after the read strobe and is zero in any cycle without a valid read.
- R3: A write at offset 0x0 sets the value driven on the output lines. A write at offset 0x4 sets the per-line output enables, where 1 means the line drives. A read at 0x4 returns the enables.
- R4: Offset 0x8 holds one interrupt-enable bit per line and reads back what was written. Write data bits at LINES and above are dropped.
- R5: In rising-edge mode, a 0-to-1 change of a synchronized line sets its bit in the capture register, which is read at offset 0xC.
- R6: In falling-edge mode, only a 1-to-0 change of a synchronized line sets its capture bit.
- R7: In both-edges mode, any change of a synchronized line sets its capture bit.
- R8: In level mode, the pending set is the synchronized level ANDed with the enables. The capture register reads zero, and writes to it have no effect.
- R9: A write at offset 0xC clears exactly the capture bits that are 1 in the write data. All other capture bits keep their values.
- R10: When a new edge and a clear hit the same capture bit in the same cycle, the bit stays set.
- R11: The interrupt output is a register. It is high one clock after any line is pending, meaning its bit is set in both the enable register and the pending source. It stays low while no enabled line is pending.
- R12: A bus access whose two lowest address bits are not zero changes no register, and a read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pin_i | input | LINES | Asynchronous line levels from the pads |
| pin_o | output | LINES | Values driven on the lines |
| pin_oe | output | LINES | Per-line output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the cycle where an edge arrives at the capture register in the same cycle as a clear of that bit. A design that gave priority to the clear would lose the interrupt there. It also writes partial clear masks, to catch a design that clears the whole register instead of only the bits written.

The bench runs all four trigger modes side by side on the same pin traffic. A design with swapped edge polarity, or with a capture register still active in level mode, would read back the wrong bits. It also disables interrupts while edges are still arriving, to show that capture continues but the interrupt stays low. Finally, it checks that misaligned writes do not alter the enables and that write data above the line count is dropped.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_BOTH  = 2'd2,
      TRIG_LEVEL = 2'd3
   } trig_e;

   localparam int BUS_W  = 32;
   localparam int ADDR_W = 4;

   // word selects taken from address bits [3:2]
   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_DIR  = 2'd1;
   localparam logic [1:0] SEL_MASK = 2'd2;
   localparam logic [1:0] SEL_CAP  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2) else $error("gpio_sync: STAGES must be at least 2");

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
   import gpio_irq_pkg::*;
#(
   parameter int    W    = 8,
   parameter trig_e MODE = TRIG_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] clr,
   output logic [W-1:0] cap
);
   if (MODE == TRIG_LEVEL) begin : g_level
      // level mode keeps no capture state
      assign cap = '0;
   end else begin : g_edge
      logic [W-1:0] prev_q;
      logic [W-1:0] det;
      logic [W-1:0] cap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= lvl;
      end

      if (MODE == TRIG_RISE) begin : g_rise
         assign det = lvl & ~prev_q;
      end else if (MODE == TRIG_FALL) begin : g_fall
         assign det = ~lvl & prev_q;
      end else begin : g_both
         assign det = lvl ^ prev_q;
      end

      // set has priority over clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cap_q <= '0;
         else        cap_q <= (cap_q & ~clr) | det;
      end

      assign cap = cap_q;

      p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (|(det & clr)) |=> ((cap_q & $past(det & clr)) == $past(det & clr)));

      p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (|(clr & ~det)) |=> ((cap_q & $past(clr & ~det)) == '0));

      p_w1c_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((cap_q & $past(~clr & ~det)) == ($past(cap_q) & $past(~clr & ~det))));
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              rd,
   input  logic [W-1:0]      lvl,
   input  logic [W-1:0]      cap,
   output logic [W-1:0]      dout_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      mask_q,
   output logic [W-1:0]      clr,
   output logic [BUS_W-1:0]  rdata_q
);
   logic       aligned;
   logic [1:0] sel;
   logic       wr_hit;
   logic [BUS_W-1:0] rmux;

   assign aligned = (addr[1:0] == 2'b00);
   assign sel     = addr[3:2];
   assign wr_hit  = wr && aligned;

   assign clr = (wr_hit && sel == SEL_CAP) ? wdata[W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         mask_q <= '0;
      end else if (wr_hit) begin
         case (sel)
            SEL_DATA: dout_q <= wdata[W-1:0];
            SEL_DIR:  dir_q  <= wdata[W-1:0];
            SEL_MASK: mask_q <= wdata[W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rmux = '0;
      if (rd && aligned) begin
         case (sel)
            SEL_DATA: rmux = BUS_W'(lvl);
            SEL_DIR:  rmux = BUS_W'(dir_q);
            SEL_MASK: rmux = BUS_W'(mask_q);
            default:  rmux = BUS_W'(cap);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rmux;
   end

   p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 4'h4) |=> (dir_q == $past(wdata[W-1:0])));

   p_misaligned_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr[1:0] != 2'b00) |=> ($stable(dir_q) && $stable(mask_q) && $stable(dout_q)));

   p_misaligned_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr[1:0] != 2'b00) |=> (rdata_q == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int    LINES = 8,
   parameter trig_e MODE  = TRIG_RISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [LINES-1:0]  pin_i,
   output logic [LINES-1:0]  pin_o,
   output logic [LINES-1:0]  pin_oe,
   output logic              irq
);
   initial assert (LINES >= 1 && LINES <= 32) else $error("gpio_irq_bank: LINES out of range 1..32");

   logic [LINES-1:0] lvl;
   logic [LINES-1:0] cap;
   logic [LINES-1:0] clr;
   logic [LINES-1:0] mask;
   logic [LINES-1:0] src;
   logic             irq_q;

   gpio_sync #(.W(LINES), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(lvl)
   );

   gpio_edge_cap #(.W(LINES), .MODE(MODE)) u_cap (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr(clr), .cap(cap)
   );

   gpio_regs #(.W(LINES)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .rd(bus_rd),
      .lvl(lvl), .cap(cap),
      .dout_q(pin_o), .dir_q(pin_oe), .mask_q(mask),
      .clr(clr), .rdata_q(bus_rdata)
   );

   if (MODE == TRIG_LEVEL) begin : g_src_level
      assign src = lvl;
   end else begin : g_src_edge
      assign src = cap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(src & mask);
   end

   assign irq = irq_q;

   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((src & mask) == '0) |=> !irq);

   p_irq_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src & mask)) |=> irq);
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
   import gpio_irq_pkg::*;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic [3:0]  addr;
   logic        wr, rd;
   logic [31:0] wdata;
   logic [W-1:0] pins;

   logic        irq_w   [4];
   logic [31:0] rdata_w [4];
   logic [W-1:0] po_w   [4];
   logic [W-1:0] oe_w   [4];

   for (genvar m = 0; m < 4; m++) begin : g_mode
      gpio_irq_bank #(.LINES(W), .MODE(trig_e'(m))) dut (
         .clk(clk), .rst_n(rst_n),
         .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rd(rd),
         .bus_rdata(rdata_w[m]),
         .pin_i(pins), .pin_o(po_w[m]), .pin_oe(oe_w[m]), .irq(irq_w[m])
      );
   end

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string cur_tag = "R1";
   string mtag [4] = '{"R5", "R6", "R7", "R8"};

   // reference state
   logic [W-1:0] m_q1, m_sync, m_prev, m_dir, m_mask, m_dout;
   logic [W-1:0] m_cap   [4];
   logic         m_irq   [4];
   logic [31:0]  m_rdata [4];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_q1 = '0; m_sync = '0; m_prev = '0;
      m_dir = '0; m_mask = '0; m_dout = '0;
      for (int m = 0; m < 4; m++) begin
         m_cap[m] = '0; m_irq[m] = 1'b0; m_rdata[m] = '0;
      end
   endtask

   task automatic model_edge();
      logic [W-1:0] s_old, p_old, det, clr, pend;
      logic aligned;
      logic [1:0] sel;
      s_old = m_sync; p_old = m_prev;
      aligned = (addr[1:0] == 2'b00);
      sel = addr[3:2];
      clr = (wr && aligned && sel == 2'd3) ? wdata[W-1:0] : '0;
      for (int m = 0; m < 4; m++) begin
         case (m)
            0: det = s_old & ~p_old;
            1: det = ~s_old & p_old;
            2: det = s_old ^ p_old;
            default: det = '0;
         endcase
         pend = ((m == 3) ? s_old : m_cap[m]) & m_mask;
         m_irq[m] = |pend;
         m_rdata[m] = '0;
         if (rd && aligned) begin
            case (sel)
               2'd0: m_rdata[m] = 32'(s_old);
               2'd1: m_rdata[m] = 32'(m_dir);
               2'd2: m_rdata[m] = 32'(m_mask);
               default: m_rdata[m] = 32'(m_cap[m]);
            endcase
         end
         if (m != 3) m_cap[m] = (m_cap[m] & ~clr) | det;
      end
      if (wr && aligned) begin
         case (sel)
            2'd0: m_dout = wdata[W-1:0];
            2'd1: m_dir  = wdata[W-1:0];
            2'd2: m_mask = wdata[W-1:0];
            default: ;
         endcase
      end
      m_prev = s_old;
      m_sync = m_q1;
      m_q1   = pins;
   endtask

   task automatic compare_all();
      for (int m = 0; m < 4; m++) begin
         chk({"R11 irq ", mtag[m]}, 32'(irq_w[m]), 32'(m_irq[m]));
         chk({"R3 pin_o ", mtag[m]}, 32'(po_w[m]), 32'(m_dout));
         chk({"R3 pin_oe ", mtag[m]}, 32'(oe_w[m]), 32'(m_dir));
         chk({cur_tag, "/", mtag[m], " rdata"}, rdata_w[m], m_rdata[m]);
      end
   endtask

   // one clock: inputs already set at a falling edge
   task automatic step();
      @(posedge clk);
      if (!rst_n) model_reset(); else model_edge();
      @(negedge clk);
      compare_all();
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic bus_write(logic [3:0] a, logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1; step();
   endtask

   task automatic bus_read(logic [3:0] a);
      addr = a; rd = 1'b1; step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; addr = '0; wr = 0; rd = 0; wdata = '0; pins = '0;
      model_reset();
      @(negedge clk);
      idle(3);
      // R1: reset state at the ports
      for (int m = 0; m < 4; m++) begin
         chk("R1 irq after reset", 32'(irq_w[m]), 32'd0);
         chk("R1 pin_oe after reset", 32'(oe_w[m]), 32'd0);
         chk("R1 rdata after reset", rdata_w[m], 32'd0);
      end
      rst_n = 1'b1;
      idle(2);

      cur_tag = "R3";
      bus_write(4'h0, 32'h0000_00A5);
      bus_write(4'h4, 32'h0000_00F0);
      bus_read(4'h4);
      chk("R3 pin_o value", 32'(po_w[0]), 32'h0000_00A5);
      chk("R3 dir readback", rdata_w[0], 32'h0000_00F0);

      cur_tag = "R4";
      bus_write(4'h8, 32'hFFFF_FF0F);
      bus_read(4'h8);
      chk("R4 mask upper bits dropped", rdata_w[0], 32'h0000_000F);
      bus_write(4'h8, 32'h0000_00FF);

      cur_tag = "R2";
      pins = 8'h3C; idle(3);
      bus_read(4'h0);
      chk("R2 data read", rdata_w[0], 32'h0000_003C);

      // edge modes react; clear leftovers from the first rise
      cur_tag = "R9";
      bus_write(4'hC, 32'hFFFF_FFFF);
      pins = 8'hC3; idle(4);
      bus_read(4'hC);
      chk("R5 rising capture", rdata_w[0], 32'h0000_00C3);
      chk("R6 falling capture", rdata_w[1], 32'h0000_003C);
      chk("R7 both capture", rdata_w[2], 32'h0000_00FF);
      chk("R8 level capture reads zero", rdata_w[3], 32'h0000_0000);
      bus_write(4'hC, 32'h0000_000F);
      bus_read(4'hC);
      chk("R9 partial clear both", rdata_w[2], 32'h0000_00F0);
      bus_write(4'hC, 32'h0000_00FF);
      idle(1);

      // edge arrives in the same cycle as a clear of that bit
      cur_tag = "R10";
      pins = 8'h00; step();
      step();
      bus_write(4'hC, 32'h0000_00FF);
      bus_read(4'hC);
      chk("R10 fall edge beats clear", rdata_w[1], 32'h0000_00C3);
      chk("R10 rise cleared", rdata_w[0], 32'h0000_0000);
      pins = 8'h01; step();
      step();
      bus_write(4'hC, 32'h0000_0001);
      bus_read(4'hC);
      chk("R10 rise edge beats clear", rdata_w[0], 32'h0000_0001);
      bus_write(4'hC, 32'h0000_00FF);
      idle(2);

      // masked lines capture but do not interrupt
      cur_tag = "R11";
      bus_write(4'h8, 32'h0000_0000);
      pins = 8'hFF; idle(3);
      pins = 8'h00; idle(4);
      chk("R11 masked irq low", 32'(irq_w[2]), 32'd0);
      bus_read(4'hC);
      chk("R11 capture still set", rdata_w[2], 32'h0000_00FF);
      bus_write(4'h8, 32'h0000_0010);
      idle(2);
      chk("R11 unmasked irq high", 32'(irq_w[2]), 32'd1);
      bus_write(4'hC, 32'h0000_00FF);
      idle(2);

      cur_tag = "R8";
      bus_write(4'hC, 32'h0000_00FF);
      pins = 8'h81; bus_write(4'h8, 32'h0000_0080);
      idle(4);
      chk("R8 level irq", 32'(irq_w[3]), 32'd1);
      pins = 8'h01; idle(4);
      chk("R8 level irq drops", 32'(irq_w[3]), 32'd0);

      cur_tag = "R12";
      bus_write(4'h5, 32'h0000_0000);
      bus_write(4'h9, 32'h0000_00FF);
      bus_read(4'h4);
      chk("R12 misaligned write ignored", rdata_w[0], 32'h0000_00F0);
      bus_read(4'h6);
      chk("R12 misaligned read zero", rdata_w[0], 32'h0000_0000);

      // mixed traffic
      cur_tag = "R2";
      bus_write(4'h8, 32'h0000_00FF);
      for (int i = 0; i < 120; i++) begin
         pins = W'($urandom);
         addr = 4'($urandom);
         if (($urandom % 4) == 0) addr[1:0] = 2'b00;
         wdata = $urandom;
         wr = (($urandom % 5) == 0);
         rd = (($urandom % 2) == 0);
         step();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule